// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

The block sits beside a MAC datapath and turns per-frame status pulses into 64-bit event counts, one set for the receive direction and one for the transmit direction. Each pulse carries a descriptor: the frame length in octets, a two-bit cast code, and flags for a VLAN tag, a bad frame check sequence, an alignment error (receive only), a pause frame, a control frame and a dropped packet (receive only). In the same cycle the descriptor is classified into octet totals, good-frame counts, cast and tag counts, error classes and a seven-bin length histogram.

Software reads each counter as two 32-bit words over a registered read port. A lower-word read also latches the upper half of the same counter, so the upper-word read that follows returns a value that is coherent with the lower word. A synchronous clear input zeroes every counter at once. The maximum frame length is an input, so the top histogram bin and the oversize checks follow the configured limit.

Top module: `eth_stat_bank`

## Requirements
- R1: After reset every counter and rd_data_o read as zero. Asserting clr_i for one cycle sets every counter to zero, and a frame presented in that same cycle is not counted.
- R2: A read request on rd_en_i/rd_addr_i gives rd_data_o on the next clock, and rd_data_o holds until the next request. The word address is {dir, index[4:0], half}: dir 0 is receive and 1 is transmit, half 0 is bits 31:0 and half 1 is bits 63:32. Indices that do not exist in the chosen direction (receive 23 and above, transmit 17 and above) read as zero.
- R3: A lower-word read latches bits 63:32 of the same counter into a shadow word. Every upper-word read returns the shadow word as captured by the most recent lower-word read, whichever address is used for the upper read.
- R4: Index 0 adds the length of every frame. Index 1 adds the length of good frames only. A good frame has no FCS error, no alignment error and a length from 64 up to max_len_i inclusive.
- R5: Index 2 counts good frames. Index 3 counts every frame whose FCS error flag is set.
- R6: Cast code 0 increments index 5 (unicast), code 1 increments index 6 (multicast), code 2 increments index 7 (broadcast) and code 3 increments none of them. Index 4 counts frames with the VLAN flag set.
- R7: Frames whose length is at most max_len_i are binned by length: 64 to index 10, 65..127 to 11, 128..255 to 12, 256..511 to 13, 512..1023 to 14, 1024..1518 to 15, and 1519..max_len_i to 16. Frames below 64 octets or above max_len_i are not binned.
- R8: Receive only: index 17 counts frames shorter than 64 octets with a good FCS, 18 counts such frames with a bad FCS, 19 counts frames longer than max_len_i with a good FCS, and 20 counts such frames with a bad FCS.
- R9: Index 8 counts pause frames and index 9 counts control frames in each direction. On receive only, index 21 counts alignment errors and index 22 counts dropped packets.
- R10: A frame changes only the counters of its own direction. Receive and transmit frames in the same cycle are both counted.
- R11: Counters are 64 bits wide, and a carry out of bit 31 appears in the upper word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all counters |
| max_len_i | input | 16 | Configured maximum frame length in octets |
| rx_vld_i | input | 1 | Receive descriptor valid, one cycle per frame |
| rx_len_i | input | 16 | Receive frame length in octets |
| rx_cast_i | input | 2 | Receive cast code (0 uni, 1 multi, 2 broad, 3 none) |
| rx_vlan_i | input | 1 | Receive frame carries a VLAN tag |
| rx_crc_err_i | input | 1 | Receive frame has a bad FCS |
| rx_align_err_i | input | 1 | Receive frame has an alignment error |
| rx_pause_i | input | 1 | Receive frame is a valid pause frame |
| rx_ctrl_i | input | 1 | Receive frame is a control frame |
| rx_drop_i | input | 1 | Receive packet was dropped |
| tx_vld_i | input | 1 | Transmit descriptor valid, one cycle per frame |
| tx_len_i | input | 16 | Transmit frame length in octets |
| tx_cast_i | input | 2 | Transmit cast code (0 uni, 1 multi, 2 broad, 3 none) |
| tx_vlan_i | input | 1 | Transmit frame carries a VLAN tag |
| tx_crc_err_i | input | 1 | Transmit frame has a bad FCS |
| tx_pause_i | input | 1 | Transmit frame is a valid pause frame |
| tx_ctrl_i | input | 1 | Transmit frame is a control frame |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | 7 | Word address {dir, index, half} |
| rd_data_o | output | 32 | Read data, valid the cycle after the request |

## Verification
The checks on mutually exclusive size classes assume that max_len_i is at least 64 octets. A smaller limit would let a runt also count as oversized, so those properties are conditioned on it. The properties that tie an octet total to a valid frame take a zero length to be a legal but silent case. The stimulus keeps the limit among 1518, 1600 and 2000, except for a long run of maximum-length jabber frames that drives the receive octet total past bit 31. Lengths are drawn both from the bin edges and from values just above and below the limit.

// File: rtl/eth_stat_pkg.sv
package eth_stat_pkg;
  localparam int LEN_W   = 16;
  localparam int CNT_W   = 64;
  localparam int WORD_W  = 32;
  localparam int IDX_W   = 5;
  localparam int ADDR_W  = IDX_W + 2;
  localparam int MIN_LEN = 64;
  localparam int N_BIN   = 7;

  // counter indices, shared part first
  localparam int C_EOCT  = 0;
  localparam int C_GOCT  = 1;
  localparam int C_GFRM  = 2;
  localparam int C_FCS   = 3;
  localparam int C_VLAN  = 4;
  localparam int C_UNI   = 5;
  localparam int C_MULTI = 6;
  localparam int C_BRD   = 7;
  localparam int C_PAUSE = 8;
  localparam int C_CTRL  = 9;
  localparam int C_BIN0  = 10;
  localparam int TX_N    = C_BIN0 + N_BIN;
  localparam int C_UNDER = TX_N;
  localparam int C_FRAG  = TX_N + 1;
  localparam int C_OVER  = TX_N + 2;
  localparam int C_JAB   = TX_N + 3;
  localparam int C_ALIGN = TX_N + 4;
  localparam int C_DROP  = TX_N + 5;
  localparam int RX_N    = TX_N + 6;

  localparam int unsigned BIN_LO [N_BIN] = '{64, 65, 128, 256, 512, 1024, 1519};

  localparam logic [1:0] CAST_UNI   = 2'd0;
  localparam logic [1:0] CAST_MULTI = 2'd1;
  localparam logic [1:0] CAST_BRD   = 2'd2;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [1:0]       cast;
    logic             vlan;
    logic             crc_err;
    logic             align_err;
    logic             pause;
    logic             ctrl;
    logic             drop;
  } frm_desc_t;
endpackage

// File: rtl/eth_stat_classify.sv
module eth_stat_classify
  import eth_stat_pkg::*;
#(
  parameter int N     = RX_N,
  parameter bit IS_RX = 1'b1
) (
  input  logic             vld_i,
  input  frm_desc_t        d_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic [N-1:0]     ev_o
);
  logic runt, over, good;

  assign runt = d_i.len < LEN_W'(MIN_LEN);
  assign over = d_i.len > max_len_i;
  assign good = !runt && !over && !d_i.crc_err && !d_i.align_err;

  assign ev_o[C_EOCT]  = vld_i;
  assign ev_o[C_GOCT]  = vld_i && good;
  assign ev_o[C_GFRM]  = vld_i && good;
  assign ev_o[C_FCS]   = vld_i && d_i.crc_err;
  assign ev_o[C_VLAN]  = vld_i && d_i.vlan;
  assign ev_o[C_UNI]   = vld_i && (d_i.cast == CAST_UNI);
  assign ev_o[C_MULTI] = vld_i && (d_i.cast == CAST_MULTI);
  assign ev_o[C_BRD]   = vld_i && (d_i.cast == CAST_BRD);
  assign ev_o[C_PAUSE] = vld_i && d_i.pause;
  assign ev_o[C_CTRL]  = vld_i && d_i.ctrl;

  for (genvar b = 0; b < N_BIN; b++) begin : g_bin
    logic [LEN_W-1:0] hi;
    if (b == N_BIN - 1) begin : g_top
      assign hi = max_len_i;
    end else begin : g_mid
      assign hi = LEN_W'(BIN_LO[b+1] - 1);
    end
    assign ev_o[C_BIN0+b] = vld_i && !over && (d_i.len >= LEN_W'(BIN_LO[b])) && (d_i.len <= hi);
  end

  if (IS_RX) begin : g_rx
    assign ev_o[C_UNDER] = vld_i && runt && !d_i.crc_err;
    assign ev_o[C_FRAG]  = vld_i && runt && d_i.crc_err;
    assign ev_o[C_OVER]  = vld_i && over && !d_i.crc_err;
    assign ev_o[C_JAB]   = vld_i && over && d_i.crc_err;
    assign ev_o[C_ALIGN] = vld_i && d_i.align_err;
    assign ev_o[C_DROP]  = vld_i && d_i.drop;
  end
endmodule

// File: rtl/eth_stat_ctr.sv
module eth_stat_ctr #(
  parameter int CNT_W = 64,
  parameter int INC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + CNT_W'(inc_i);
  end
endmodule

// File: rtl/eth_stat_dir.sv
module eth_stat_dir
  import eth_stat_pkg::*;
#(
  parameter int N     = RX_N,
  parameter bit IS_RX = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    vld_i,
  input  frm_desc_t               d_i,
  input  logic [LEN_W-1:0]        max_len_i,
  output logic [N-1:0]            ev_o,
  output logic [N-1:0][CNT_W-1:0] cnt_o
);
  eth_stat_classify #(.N(N), .IS_RX(IS_RX)) u_cls (
    .vld_i     (vld_i),
    .d_i       (d_i),
    .max_len_i (max_len_i),
    .ev_o      (ev_o)
  );

  for (genvar k = 0; k < N; k++) begin : g_ctr
    logic [LEN_W-1:0] inc;
    if (k == C_EOCT || k == C_GOCT) begin : g_oct
      assign inc = d_i.len;
    end else begin : g_one
      assign inc = LEN_W'(1);
    end
    eth_stat_ctr #(.CNT_W(CNT_W), .INC_W(LEN_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .en_i   (ev_o[k]),
      .inc_i  (inc),
      .cnt_o  (cnt_o[k])
    );
  end
endmodule

// File: rtl/eth_stat_rdport.sv
module eth_stat_rdport
  import eth_stat_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [RX_N-1:0][CNT_W-1:0] rx_cnt_i,
  input  logic [TX_N-1:0][CNT_W-1:0] tx_cnt_i,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [WORD_W-1:0]          rd_data_o
);
  logic              dir, hi;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  sel;
  logic [WORD_W-1:0] shadow_q;

  assign dir = rd_addr_i[ADDR_W-1];
  assign idx = rd_addr_i[ADDR_W-2:1];
  assign hi  = rd_addr_i[0];

  always_comb begin
    sel = '0;
    if (!dir) begin
      for (int k = 0; k < RX_N; k++) if (idx == IDX_W'(k)) sel = rx_cnt_i[k];
    end else begin
      for (int k = 0; k < TX_N; k++) if (idx == IDX_W'(k)) sel = tx_cnt_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      shadow_q  <= '0;
    end else if (rd_en_i) begin
      if (hi) begin
        rd_data_o <= shadow_q;
      end else begin
        rd_data_o <= sel[WORD_W-1:0];
        shadow_q  <= sel[CNT_W-1:WORD_W];
      end
    end
  end
endmodule

// File: rtl/eth_stat_bank.sv
module eth_stat_bank
  import eth_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              rx_vld_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  input  logic [1:0]        rx_cast_i,
  input  logic              rx_vlan_i,
  input  logic              rx_crc_err_i,
  input  logic              rx_align_err_i,
  input  logic              rx_pause_i,
  input  logic              rx_ctrl_i,
  input  logic              rx_drop_i,
  input  logic              tx_vld_i,
  input  logic [LEN_W-1:0]  tx_len_i,
  input  logic [1:0]        tx_cast_i,
  input  logic              tx_vlan_i,
  input  logic              tx_crc_err_i,
  input  logic              tx_pause_i,
  input  logic              tx_ctrl_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  frm_desc_t rx_d, tx_d;
  logic [RX_N-1:0][CNT_W-1:0] rx_cnt_q;
  logic [TX_N-1:0][CNT_W-1:0] tx_cnt_q;
  logic [RX_N-1:0] rx_ev;
  logic [TX_N-1:0] tx_ev;

  assign rx_d = '{len: rx_len_i, cast: rx_cast_i, vlan: rx_vlan_i, crc_err: rx_crc_err_i,
                  align_err: rx_align_err_i, pause: rx_pause_i, ctrl: rx_ctrl_i, drop: rx_drop_i};
  // transmit side has no alignment or drop status
  assign tx_d = '{len: tx_len_i, cast: tx_cast_i, vlan: tx_vlan_i, crc_err: tx_crc_err_i,
                  align_err: 1'b0, pause: tx_pause_i, ctrl: tx_ctrl_i, drop: 1'b0};

  eth_stat_dir #(.N(RX_N), .IS_RX(1'b1)) u_rx (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr_i), .vld_i (rx_vld_i),
    .d_i (rx_d), .max_len_i (max_len_i), .ev_o (rx_ev), .cnt_o (rx_cnt_q)
  );

  eth_stat_dir #(.N(TX_N), .IS_RX(1'b0)) u_tx (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr_i), .vld_i (tx_vld_i),
    .d_i (tx_d), .max_len_i (max_len_i), .ev_o (tx_ev), .cnt_o (tx_cnt_q)
  );

  eth_stat_rdport u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_cnt_i  (rx_cnt_q),
    .tx_cnt_i  (tx_cnt_q),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/eth_stat_bank_chk.sv
module eth_stat_bank_chk
  import eth_stat_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       clr_i,
  input logic [LEN_W-1:0]           max_len_i,
  input logic                       rx_vld_i,
  input logic [LEN_W-1:0]           rx_len_i,
  input logic                       tx_vld_i,
  input logic                       rd_en_i,
  input logic [WORD_W-1:0]          rd_data_o,
  input logic [RX_N-1:0][CNT_W-1:0] rx_cnt_q,
  input logic [TX_N-1:0][CNT_W-1:0] tx_cnt_q,
  input logic [RX_N-1:0]            rx_ev,
  input logic [TX_N-1:0]            tx_ev
);
  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rx_cnt_q == '0) && (tx_cnt_q == '0)); // R1

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R2

  AST_EOCT_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_i && !clr_i && (rx_len_i != '0)) |=> (rx_cnt_q[C_EOCT] != $past(rx_cnt_q[C_EOCT]))); // R4

  AST_RX_BIN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_ev[C_BIN0 +: N_BIN])); // R7

  AST_TX_BIN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_ev[C_BIN0 +: N_BIN])); // R7

  AST_SIZE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_len_i >= LEN_W'(MIN_LEN)) |-> $onehot0({rx_ev[C_JAB:C_UNDER], |rx_ev[C_BIN0 +: N_BIN]})); // R8

  AST_RX_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_vld_i && !clr_i) |=> $stable(rx_cnt_q)); // R10

  AST_TX_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_vld_i && !clr_i) |=> $stable(tx_cnt_q)); // R10
endmodule

bind eth_stat_bank eth_stat_bank_chk u_chk (.*);

// File: tb/eth_stat_bank_bench.sv
`timescale 1ns/1ps
module eth_stat_bank_bench;
  localparam int NRX = 23;
  localparam int NTX = 17;
  localparam int CORNER [14] = '{0, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519};

  logic clk_i = 1'b0, rst_ni = 1'b0, clr_i = 1'b0;
  logic [15:0] max_len_i = 16'd1518;
  logic rx_vld_i = 0, rx_vlan_i = 0, rx_crc_err_i = 0, rx_align_err_i = 0, rx_pause_i = 0, rx_ctrl_i = 0, rx_drop_i = 0;
  logic [15:0] rx_len_i = '0;
  logic [1:0]  rx_cast_i = '0;
  logic tx_vld_i = 0, tx_vlan_i = 0, tx_crc_err_i = 0, tx_pause_i = 0, tx_ctrl_i = 0;
  logic [15:0] tx_len_i = '0;
  logic [1:0]  tx_cast_i = '0;
  logic rd_en_i = 0;
  logic [6:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] m_rx [NRX];
  logic [63:0] m_tx [NTX];

  always #2.5 clk_i = ~clk_i;

  eth_stat_bank u_eth_stat_bank (.*);

  function automatic string req_of(int idx);
    if (idx <= 1) return "R4";
    if (idx <= 3) return "R5";
    if (idx <= 7) return "R6";
    if (idx <= 9) return "R9";
    if (idx <= 16) return "R7";
    if (idx <= 20) return "R8";
    return "R9";
  endfunction

  function automatic void model_clear();
    for (int k = 0; k < NRX; k++) m_rx[k] = '0;
    for (int k = 0; k < NTX; k++) m_tx[k] = '0;
  endfunction

  function automatic void bump(bit rx, int idx, logic [63:0] amt);
    if (rx) m_rx[idx] = m_rx[idx] + amt;
    else    m_tx[idx] = m_tx[idx] + amt;
  endfunction

  function automatic void model_frame(bit rx, int len, int cast, bit vlan, bit fcs, bit aln,
                                      bit pause, bit ctrl, bit drop, int mx);
    bit short_f = len < 64;
    bit long_f  = len > mx;
    bit good    = !short_f && !long_f && !fcs && !aln;
    int bin     = -1;
    bump(rx, 0, 64'(len));
    if (good) begin bump(rx, 1, 64'(len)); bump(rx, 2, 1); end
    if (fcs) bump(rx, 3, 1);
    if (vlan) bump(rx, 4, 1);
    if (cast < 3) bump(rx, 5 + cast, 1);
    if (pause) bump(rx, 8, 1);
    if (ctrl) bump(rx, 9, 1);
    if (!short_f && !long_f) begin
      if (len == 64) bin = 10;
      else if (len <= 127) bin = 11;
      else if (len <= 255) bin = 12;
      else if (len <= 511) bin = 13;
      else if (len <= 1023) bin = 14;
      else if (len <= 1518) bin = 15;
      else bin = 16;
      bump(rx, bin, 1);
    end
    if (rx) begin
      if (short_f) bump(rx, fcs ? 18 : 17, 1);
      if (long_f)  bump(rx, fcs ? 20 : 19, 1);
      if (aln)  bump(rx, 21, 1);
      if (drop) bump(rx, 22, 1);
    end
  endfunction

  function automatic int pick_len();
    int r = int'($urandom % 10);
    if (r < 3) return int'($urandom % 2100);
    if (r == 3) return int'(max_len_i);
    if (r == 4) return int'(max_len_i) + 1;
    return CORNER[$urandom % 14];
  endfunction

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rx_vld_i = 0; tx_vld_i = 0;
    rd_en_i = 1; rd_addr_i = a;
    @(negedge clk_i);
    rd_en_i = 0;
    d = rd_data_o;
  endtask

  task automatic check_ctr(bit rx, int idx);
    logic [31:0] lo, hi;
    logic [63:0] exp;
    exp = rx ? m_rx[idx] : m_tx[idx];
    rd({~rx, 5'(idx), 1'b0}, lo);
    rd({~rx, 5'(idx), 1'b1}, hi);
    checks++;
    if ({hi, lo} !== exp) begin
      errors++;
      $display("FAIL %s %s idx %0d actual=%h expected=%h", req_of(idx), rx ? "rx" : "tx", idx, {hi, lo}, exp);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < NRX; k++) check_ctr(1'b1, k);
    for (int k = 0; k < NTX; k++) check_ctr(1'b0, k); // R10 direction isolation
  endtask

  task automatic drive_cycle(bit rx_on, bit tx_on);
    @(negedge clk_i);
    rx_vld_i = rx_on; tx_vld_i = tx_on;
    if (rx_on) begin
      rx_len_i = 16'(pick_len()); rx_cast_i = 2'($urandom % 4);
      rx_vlan_i = ($urandom % 4) == 0; rx_crc_err_i = ($urandom % 6) == 0;
      rx_align_err_i = ($urandom % 8) == 0; rx_pause_i = ($urandom % 5) == 0;
      rx_ctrl_i = ($urandom % 5) == 0; rx_drop_i = ($urandom % 6) == 0;
      model_frame(1'b1, int'(rx_len_i), int'(rx_cast_i), rx_vlan_i, rx_crc_err_i, rx_align_err_i,
                  rx_pause_i, rx_ctrl_i, rx_drop_i, int'(max_len_i));
    end
    if (tx_on) begin
      tx_len_i = 16'(pick_len()); tx_cast_i = 2'($urandom % 4);
      tx_vlan_i = ($urandom % 4) == 0; tx_crc_err_i = ($urandom % 6) == 0;
      tx_pause_i = ($urandom % 5) == 0; tx_ctrl_i = ($urandom % 5) == 0;
      model_frame(1'b0, int'(tx_len_i), int'(tx_cast_i), tx_vlan_i, tx_crc_err_i, 1'b0,
                  tx_pause_i, tx_ctrl_i, 1'b0, int'(max_len_i));
    end
  endtask

  initial begin
    logic [31:0] d, held;
    void'($urandom(32'd4242));
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check32("R1", "rd_data after reset", rd_data_o, 32'h0);
    check_ctr(1'b1, 0);
    check_ctr(1'b0, 2);

    // directed bin edges on receive, transmit idle (R7, R8, R10)
    max_len_i = 16'd1600;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk_i);
      rx_vld_i = 1; tx_vld_i = 0; rx_len_i = 16'(CORNER[k]); rx_cast_i = 2'(k % 4);
      rx_vlan_i = 0; rx_crc_err_i = k[0]; rx_align_err_i = 0; rx_pause_i = 0; rx_ctrl_i = 0; rx_drop_i = 0;
      model_frame(1'b1, CORNER[k], k % 4, 1'b0, k[0], 1'b0, 1'b0, 1'b0, 1'b0, 1600);
    end
    check_all();

    // random mixed traffic over three limits
    for (int p = 0; p < 3; p++) begin
      max_len_i = (p == 0) ? 16'd1518 : (p == 1) ? 16'd1600 : 16'd2000;
      for (int c = 0; c < 600; c++) drive_cycle(($urandom % 4) != 0, ($urandom % 4) != 0);
    end
    check_all();

    // unmapped indices and read-data hold (R2)
    rd({1'b1, 5'd20, 1'b0}, d);
    check32("R2", "unmapped tx index", d, 32'h0);
    rd({1'b0, 5'd30, 1'b0}, d);
    check32("R2", "unmapped rx index", d, 32'h0);
    rd({1'b0, 5'd0, 1'b0}, held);
    repeat (3) @(negedge clk_i);
    check32("R2", "rd_data hold", rd_data_o, held);
    check32("R2", "lower word of rx octets", held, m_rx[0][31:0]);

    // clear beats a same-cycle frame (R1)
    @(negedge clk_i);
    clr_i = 1; rx_vld_i = 1; tx_vld_i = 1; rx_len_i = 16'd100; tx_len_i = 16'd100;
    @(negedge clk_i);
    clr_i = 0; rx_vld_i = 0; tx_vld_i = 0;
    model_clear();
    check_all();

    // long jabber run: carry into upper word (R11), shadow behaviour (R3)
    max_len_i = 16'd1518;
    for (int c = 0; c < 65540; c++) begin
      @(negedge clk_i);
      rx_vld_i = 1; rx_len_i = 16'hFFFF; rx_cast_i = 2'd0; rx_vlan_i = 0; rx_crc_err_i = 1;
      rx_align_err_i = 0; rx_pause_i = 0; rx_ctrl_i = 0; rx_drop_i = 0;
      model_frame(1'b1, 65535, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1518);
    end
    rd({1'b0, 5'd0, 1'b0}, d);
    check32("R11", "rx octets lower after carry", d, 32'd196604);
    rd({1'b0, 5'd3, 1'b1}, d);
    check32("R3", "upper read via other index returns shadow", d, 32'd1);
    rd({1'b0, 5'd0, 1'b1}, d);
    check32("R11", "rx octets upper after carry", d, 32'd1);
    check_all();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule